// File: doc/BRIEF.md
# Modem Control and Status Unit

This block sits between a serial port's host bus and the handshake lines of an attached modem or peripheral. It keeps a small control register whose bits drive the active-low data-terminal-ready and request-to-send outputs and the output enable of the port's interrupt pin. It also watches the four active-low handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. It reports them in a status register together with sticky change flags, and it raises a modem interrupt request while any change flag is set.

The host reaches both registers through one write strobe, one read strobe, a one-bit register select and an 8-bit data path. A loopback bit in the control register is used for diagnostics. While it is set, the status register reports the control bits instead of the pins, the external handshake inputs are ignored, and the two control outputs rest inactive. Change detection works the same way on these internal values, so software can exercise the whole status and interrupt path without a cable.

Top module: `modem_ctl_unit`

## Requirements
- R1: A write with `reg_sel`=0 stores `wr_data[4:0]` in the control register. A read with `reg_sel`=0 returns those five bits, and bits 7 to 5 always read as 0.
- R2: Outside loopback, `dtr_n` is low exactly when control bit 0 is 1, and `rts_n` is low exactly when control bit 1 is 1. After reset both are high.
- R3: `irq_oe` equals control bit 3. A 0 there means the interrupt pin is to float.
- R4: With `reg_sel`=1, `rd_data[7:4]` gives the inverted levels of `cts_n`, `dsr_n`, `ri_n` and `cd_n`, with `cts_n` in bit 4 and `cd_n` in bit 7. Each input passes through a two-flop synchronizer, so a change at the pin shows in these bits two clock edges later.
- R5: While control bit 4 is 1 (loopback), `rd_data[7:4]` equal control bits 1, 0, 2 and 3 (bit 4 through bit 7). The external handshake inputs have no effect, and `dtr_n` and `rts_n` are held high.
- R6: Status bits 0, 1 and 3 (change flags) set on any change of the bit 4, 5 and 7 level. Bit 2 sets only when the bit 6 level falls from 1 to 0, which is `ri_n` rising from low to high. A flag becomes visible one edge after its level bit changes.
- R7: A read strobe with `reg_sel`=1 clears all four change flags at that edge. A change detected at the same edge leaves its flag set. `msi_req` is high exactly while any change flag is 1.
- R8: Reset clears the control register and the change flags. The levels present on the inputs at reset produce no change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears flags) |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring indicator input, active low |
| cd_n | input | 1 | Carrier detect input, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| irq_oe | output | 1 | Output enable for the interrupt pin |
| msi_req | output | 1 | Modem status interrupt request |

## Verification
The bench issues a status read on exactly the edge where a synchronized carrier change lands. A design that let the clear win would lose that event, and the flag would read 0. It pulses the ring input low and then high, and expects a flag only on the release. A design that flagged both edges would interrupt on the leading edge. It enters and leaves loopback while toggling the external pins. This exposes pins that leak into the status bits, control outputs that keep driving, or a missed trailing edge on the internal ring bit. It also holds an input active through reset, which catches a synchronizer fill that is mistaken for a change.

// File: rtl/mcs_pkg.sv
// Package: shared constants for the modem control and status unit.
// Assumes a one-bit register select and an 8-bit host data path.
package mcs_pkg;
    localparam int DATA_W   = 8;
    localparam int CTL_W    = 5;
    localparam int LINES    = 4;
    localparam int SYNC_DEF = 2;

    // Register select values
    localparam logic SEL_CTL  = 1'b0;
    localparam logic SEL_STAT = 1'b1;

    // Control register bit positions
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_AUX  = 2;
    localparam int C_IRQE = 3;
    localparam int C_LOOP = 4;

    // Line index order inside the status nibbles
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_CD  = 3;
endpackage

// File: rtl/mcs_sync.sv
// Module: multi-flop synchronizer for slow asynchronous level inputs.
// Assumes inputs are quasi-static lines; each bit is synchronized independently.
module mcs_sync #(
    parameter int          WIDTH  = 4,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw asynchronous value
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage re-registers the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/mcs_ctrl_reg.sv
// Module: control register and the handshake outputs it drives.
// Assumes the write strobe is already qualified by the register select.
module mcs_ctrl_reg
    import mcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              irq_oe,
    output logic              loop_en
);
    // Holds the five writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= wr_data[CTL_W-1:0];
    end

    // Derives outputs; loopback parks both handshake outputs inactive
    always_comb begin
        loop_en = ctl_q[C_LOOP];
        dtr_n   = !(ctl_q[C_DTR] && !loop_en);
        rts_n   = !(ctl_q[C_RTS] && !loop_en);
        irq_oe  = ctl_q[C_IRQE];
    end

    p_write_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (ctl_q == $past(wr_data[CTL_W-1:0])));
endmodule

// File: rtl/mcs_status.sv
// Module: synchronizes modem inputs, selects loopback levels, keeps change flags.
// Assumes pins_n are active low; loop_lvl is already in active-high line order.
module mcs_status
    import mcs_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pins_n,
    input  logic             loop_en,
    input  logic [LINES-1:0] loop_lvl,
    input  logic             rd_clr,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] delta
);
    localparam int SETTLE   = SYNC_STAGES + 1;
    localparam int SETTLE_W = $clog2(SETTLE + 1);

    logic [LINES-1:0]    pins_s;
    logic [LINES-1:0]    prev_lvl;
    logic [LINES-1:0]    chg;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                settled;

    mcs_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_n),
        .q_sync  (pins_s)
    );

    // Chooses the reported levels: internal bits in loopback, else inverted pins
    assign lvl = loop_en ? loop_lvl : ~pins_s;

    // Counts edges after reset until the synchronizer holds real pin values
    always_ff @(posedge clk) begin
        if (!rst_n)                           settle_cnt <= '0;
        else if (settle_cnt != SETTLE_W'(SETTLE)) settle_cnt <= settle_cnt + 1'b1;
    end
    assign settled = (settle_cnt == SETTLE_W'(SETTLE));

    // Remembers last cycle's levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= lvl;
    end

    // Finds changes: any edge on three lines, falling level only on ring
    always_comb begin
        chg        = lvl ^ prev_lvl;
        chg[L_RI]  = prev_lvl[L_RI] && !lvl[L_RI];
        if (!settled) chg = '0;
    end

    // Sticky flags: read clears, a coincident change still sets
    always_ff @(posedge clk) begin
        if (!rst_n) delta <= '0;
        else        delta <= (rd_clr ? '0 : delta) | chg;
    end

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (chg == '0)) |=> (delta == '0));
    p_ri_no_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[L_RI] && !delta[L_RI]) |=> !delta[L_RI]);
    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((delta & $past(delta)) == $past(delta)));
endmodule

// File: rtl/modem_ctl_unit.sv
// Module: top of the modem control and status unit; decodes the host strobes
// and multiplexes read data. Assumes strobes last one cycle per access.
module modem_ctl_unit
    import mcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       reg_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       cd_n,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       irq_oe,
    output logic       msi_req
);
    logic [CTL_W-1:0] ctl_q;
    logic             loop_en;
    logic [LINES-1:0] loop_lvl;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] delta;
    logic             wr_ctl;
    logic             rd_clr;

    // Qualifies strobes with the register select
    assign wr_ctl = wr_en && (reg_sel == SEL_CTL);
    assign rd_clr = rd_en && (reg_sel == SEL_STAT);

    mcs_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (wr_ctl),
        .wr_data (wr_data),
        .ctl_q   (ctl_q),
        .dtr_n   (dtr_n),
        .rts_n   (rts_n),
        .irq_oe  (irq_oe),
        .loop_en (loop_en)
    );

    // Maps control bits onto the status line order for loopback
    always_comb begin
        loop_lvl        = '0;
        loop_lvl[L_CTS] = ctl_q[C_RTS];
        loop_lvl[L_DSR] = ctl_q[C_DTR];
        loop_lvl[L_RI]  = ctl_q[C_AUX];
        loop_lvl[L_CD]  = ctl_q[C_IRQE];
    end

    mcs_status #(.SYNC_STAGES(SYNC_DEF)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_n   ({cd_n, ri_n, dsr_n, cts_n}),
        .loop_en  (loop_en),
        .loop_lvl (loop_lvl),
        .rd_clr   (rd_clr),
        .lvl      (lvl),
        .delta    (delta)
    );

    // Selects the register image returned to the host
    always_comb begin
        if (reg_sel == SEL_STAT) rd_data = {lvl, delta};
        else                     rd_data = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
        msi_req = |delta;
    end

    p_loop_pins_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (dtr_n && rts_n));
    p_irq_follows_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (delta != '0) |-> msi_req);
endmodule

// File: tb/tb_modem_ctl_unit.sv
module tb_modem_ctl_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0, reg_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic cts_n = 1, dsr_n = 1, ri_n = 1, cd_n = 1;
    logic dtr_n, rts_n, irq_oe, msi_req;

    int errors = 0, checks = 0;
    bit cmp_on = 0;

    modem_ctl_unit dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [4:0] m_ctl;
    logic [3:0] m_flag, m_last;
    logic [3:0] m_pipe[$];
    int         m_edges;

    function automatic logic [3:0] m_level();
        if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
        return ~m_pipe[0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 0; m_flag = 0; m_last = 0; m_edges = 0;
            m_pipe = {4'hF, 4'hF};
        end else begin
            logic [3:0] now, ev;
            now = m_level();
            ev  = 4'b0;
            if (m_edges > 2) begin
                for (int i = 0; i < 4; i++)
                    if (i == 2) ev[i] = m_last[i] & ~now[i];
                    else        ev[i] = m_last[i] ^ now[i];
            end
            if (rd_en && reg_sel) m_flag = 0;
            m_flag = m_flag | ev;
            m_last = now;
            if (wr_en && !reg_sel) m_ctl = wr_data[4:0];
            void'(m_pipe.pop_front());
            m_pipe.push_back({cd_n, ri_n, dsr_n, cts_n});
            if (m_edges < 100) m_edges++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compares every output with the model just after each edge
    always begin
        @(posedge clk); #1;
        if (cmp_on && rst_n) begin
            logic [7:0] er;
            er = reg_sel ? {m_level(), m_flag} : {3'b0, m_ctl};
            chk(rd_data == er, "R1/R4/R5/R6 rd_data", rd_data, er);
            chk(dtr_n == !(m_ctl[0] && !m_ctl[4]), "R2 dtr_n", dtr_n, !(m_ctl[0] && !m_ctl[4]));
            chk(rts_n == !(m_ctl[1] && !m_ctl[4]), "R2 rts_n", rts_n, !(m_ctl[1] && !m_ctl[4]));
            chk(irq_oe == m_ctl[3], "R3 irq_oe", irq_oe, m_ctl[3]);
            chk(msi_req == (|m_flag), "R7 msi_req", msi_req, |m_flag);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_sel = 0; wr_data = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask
    task automatic rd_stat();
        @(negedge clk); reg_sel = 1; rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask
    task automatic look(input logic sel, input logic [7:0] exp, input string tag);
        @(negedge clk); reg_sel = sel; #1;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic run();
        cts_n = 0;
        cyc(3); rst_n = 1; cmp_on = 1;
        cyc(5);
        look(1, 8'h10, "R8 no flag from reset-time levels");
        look(0, 8'h00, "R1 reset control");
        chk(dtr_n && rts_n, "R2 reset pins high", {dtr_n, rts_n}, 3);
        wr(8'hEB);
        look(0, 8'h0B, "R1 upper bits read zero");
        chk(!dtr_n && !rts_n, "R2 pins driven low", {dtr_n, rts_n}, 0);
        chk(irq_oe == 1, "R3 irq enable", irq_oe, 1);
        @(negedge clk); dsr_n = 0; cyc(4);
        look(1, 8'h32, "R6 dsr change flag");
        rd_stat();
        look(1, 8'h30, "R7 read clears flags");
        @(negedge clk); ri_n = 0; cyc(4);
        look(1, 8'h70, "R6 ring leading edge ignored");
        @(negedge clk); ri_n = 1; cyc(4);
        look(1, 8'h34, "R6 ring trailing edge flagged");
        chk(msi_req == 1, "R7 request raised", msi_req, 1);
        rd_stat();
        // carrier change lands on the same edge as a status read
        @(negedge clk); cd_n = 0;
        @(negedge clk);
        @(negedge clk); reg_sel = 1; rd_en = 1;
        @(negedge clk); rd_en = 0;
        look(1, 8'hB8, "R7 change beats clear");
        rd_stat();
        wr(8'h17);
        cyc(2);
        look(1, 8'h78, "R5 loopback levels");
        chk(dtr_n && rts_n, "R5 pins idle in loopback", {dtr_n, rts_n}, 3);
        @(negedge clk); cts_n = 1; dsr_n = 1; cd_n = 1; cyc(4);
        look(1, 8'h78, "R5 external inputs ignored");
        wr(8'h13);
        cyc(1);
        look(1, 8'h3C, "R6 loopback ring trailing edge");
        wr(8'h00);
        cyc(4);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cts_n = k[0]; cd_n = k[2]; ri_n = k[1];
            rd_en = (k % 3 == 0); reg_sel = k[3];
        end
        @(negedge clk); rd_en = 0; cyc(4);
        @(negedge clk); cts_n = 0; cyc(4);
        @(negedge clk); rst_n = 0; cyc(2); rst_n = 1; cyc(5);
        look(1, 8'h10, "R8 flags cleared by reset");
        look(0, 8'h00, "R8 control cleared by reset");
        cyc(3);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (WATCHDOG) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        disable fork;
        cmp_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule